// File: doc/BRIEF.md
# Predecoding Two-Way Instruction Fetch Cache

This block is the first level of instruction storage for a fetch unit. Each accepted fetch request gives a byte address. One cycle later the block returns up to four consecutive 32-bit instruction words, starting at the word that the address selects. A group may start at any word of a 16-word line, but it never runs past the end of that line. When the start word is among the last three words of the line, only the words up to the end of the line come back, in the low lanes. The cache has two ways per set. On a miss the block reports not-hit and keeps taking requests, so the requester decides when to fetch the line from memory.

Lines come in through a refill port in one cycle as a whole line. On the way in, every word passes a predecoder. The predecoder attaches a 4-bit execution-unit select code to the word and stores a parity bit over the word and its code. The fetch port uses valid/ready. A request transfers in a cycle in which `req_valid` and `req_ready` are both high. `req_ready` is low only in a cycle that carries a refill, because the write takes the arrays for that cycle. The response port has no back-pressure: `rsp_valid` is a one-cycle pulse, and the requester must take the group when it appears. The default has 16 sets (2 KB). Setting `SETS` to 256 gives 32 KB.

Top module: `ifc_fetch_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, `rsp_valid` is 0, and the first fetch to any address misses.
- R2: `rsp_valid` is high exactly one cycle after each accepted request, and at no other time.
- R3: On a miss, `rsp_hit` is 0 and all of `rsp_lane_valid` is 0. `req_ready` stays 1, so requests in back-to-back cycles are all accepted.
- R4: A refill writes all 16 words of the line addressed by `refill_addr` into the least-recently-used way of its set and marks that way valid. A later fetch of that line hits and returns the written words.
- R5: On a hit with word offset o = `req_addr[5:2]`, lane i (bits 32i+31..32i of `rsp_words`) carries line word o+i.
- R6: Lane i is valid only if o+i <= 15. For offsets 13, 14 and 15 the lane-valid vector is 0111, 0011 and 0001.
- R7: Lane i of `rsp_codes` (bits 4i+3..4i) is the unit code of the word, decoded from its bits 31:26. Opcode 0x00 and 0x08..0x0F give 0001. Opcodes 0x02..0x07 give 0010. Opcodes 0x20..0x2F give 0100. Opcode 0x11 gives 1000. All other opcodes give 0000.
- R8: Each stored word keeps a parity bit that makes the word, its code and the bit together even. A lane whose stored bits have odd parity raises its `rsp_perr` bit. `refill_flip[w]` inverts bit 0 of word w after its parity is computed. The bit never rises for an invalid lane.
- R9: A hit makes the other way of its set least recently used. A refill makes the way it wrote most recently used, so a third line evicts the line used less recently.
- R10: While `refill_valid` is high, `req_ready` is 0 and a request in that cycle is not accepted and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Request is accepted this cycle |
| req_addr | input | 32 | Fetch byte address; bits 5:2 give the start word |
| rsp_valid | output | 1 | Response group present (one-cycle pulse) |
| rsp_hit | output | 1 | Line found in exactly one way |
| rsp_lane_valid | output | 4 | Per-lane valid |
| rsp_words | output | 128 | Four instruction words, lane 0 in the low bits |
| rsp_codes | output | 16 | Four unit-select codes |
| rsp_perr | output | 4 | Per-lane parity error |
| refill_valid | input | 1 | Write one line this cycle |
| refill_addr | input | 32 | Byte address of the line being written |
| refill_line | input | 512 | 16 words, word 0 in the low bits |
| refill_flip | input | 16 | Error injection: inverts bit 0 of the chosen words |

## Verification
Most corrupted internal state shows up at the ports one cycle after the next fetch that touches it:
- A wrong valid or tag bit turns an expected hit into a miss, or the reverse.
- A wrong lane offset shifts the words across the lanes.
- A bad parity bit raises `rsp_perr` on a clean word.

A wrong LRU bit stays hidden for longer. It appears only at the third refill into the same set, when the wrong line is evicted and a fetch that should hit then misses. For that reason the bench fills one set with two lines, touches one of them, adds a third line, and then fetches all three.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  localparam int OPC_W  = 6;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] UNIT_NONE = 4'b0000;
  localparam logic [CODE_W-1:0] UNIT_INT  = 4'b0001;
  localparam logic [CODE_W-1:0] UNIT_BR   = 4'b0010;
  localparam logic [CODE_W-1:0] UNIT_MEM  = 4'b0100;
  localparam logic [CODE_W-1:0] UNIT_FP   = 4'b1000;

  // Map the major opcode field to the execution unit that will take the word.
  function automatic logic [CODE_W-1:0] unit_sel(input logic [OPC_W-1:0] op);
    logic [CODE_W-1:0] c;
    c = UNIT_NONE;
    if (op == 6'h00 || op[5:3] == 3'b001) c = UNIT_INT;
    else if (op >= 6'h02 && op <= 6'h07) c = UNIT_BR;
    else if (op[5:4] == 2'b10)          c = UNIT_MEM;
    else if (op == 6'h11)               c = UNIT_FP;
    return c;
  endfunction
endpackage

// File: rtl/ifc_predecode.sv
module ifc_predecode
  import ifc_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NWORDS = 16,
  localparam int ENT_W = WORD_W + CODE_W + 1
) (
  input  logic [NWORDS*WORD_W-1:0] words,
  input  logic [NWORDS-1:0]        flip,
  output logic [NWORDS*ENT_W-1:0]  entries
);
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [WORD_W-1:0] w;
    logic [CODE_W-1:0] code;
    logic              par;
    assign w    = words[g*WORD_W +: WORD_W];
    assign code = unit_sel(w[WORD_W-1 -: OPC_W]);
    assign par  = ^{code, w};
    // Injected fault lands after the parity bit is formed.
    assign entries[g*ENT_W +: ENT_W] =
      {par, code, w ^ {{(WORD_W-1){1'b0}}, flip[g]}};
  end
endmodule

// File: rtl/ifc_tag_array.sv
module ifc_tag_array #(
  parameter int SETS  = 16,
  parameter int TAG_W = 22,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_en,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic             lk_way,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  output logic             wr_way
);
  logic [TAG_W-1:0] tags [2][SETS];
  logic [1:0]       vld  [SETS];
  logic [SETS-1:0]  lru;           // way to replace next
  logic             m0, m1;

  assign m0     = vld[lk_idx][0] && (tags[0][lk_idx] == lk_tag);
  assign m1     = vld[lk_idx][1] && (tags[1][lk_idx] == lk_tag);
  assign lk_hit = m0 ^ m1;
  assign lk_way = m1;
  assign wr_way = lru[wr_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lru <= '0;
      for (int s = 0; s < SETS; s++) vld[s] <= 2'b00;
    end else if (wr_en) begin
      tags[wr_way][wr_idx]   <= wr_tag;
      vld[wr_idx][wr_way]    <= 1'b1;
      lru[wr_idx]            <= ~wr_way;
    end else if (lk_en && lk_hit) begin
      lru[lk_idx] <= ~lk_way;
    end
  end
endmodule

// File: rtl/ifc_data_array.sv
module ifc_data_array #(
  parameter int SETS   = 16,
  parameter int LINE_W = 592,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_way,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_way,
  output logic [LINE_W-1:0] rd_line
);
  logic [LINE_W-1:0] mem [2*SETS];

  assign rd_line = mem[{rd_way, rd_idx}];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_way, wr_idx}] <= wr_line;
  end
endmodule

// File: rtl/ifc_fetch_cache.sv
module ifc_fetch_cache
  import ifc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 16,
  parameter int SETS       = 16,
  parameter int FETCH_W    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [ADDR_W-1:0]            req_addr,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic [FETCH_W-1:0]           rsp_lane_valid,
  output logic [FETCH_W*WORD_W-1:0]    rsp_words,
  output logic [FETCH_W*CODE_W-1:0]    rsp_codes,
  output logic [FETCH_W-1:0]           rsp_perr,
  input  logic                         refill_valid,
  input  logic [ADDR_W-1:0]            refill_addr,
  input  logic [LINE_WORDS*WORD_W-1:0] refill_line,
  input  logic [LINE_WORDS-1:0]        refill_flip
);
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - BYTE_W - OFF_W - IDX_W;
  localparam int ENT_W  = WORD_W + CODE_W + 1;
  localparam int LINE_W = LINE_WORDS * ENT_W;
  localparam int IDX_LO = BYTE_W + OFF_W;
  localparam int TAG_LO = IDX_LO + IDX_W;

  logic [OFF_W-1:0]  rq_off;
  logic [IDX_W-1:0]  rq_idx, rf_idx;
  logic [TAG_W-1:0]  rq_tag, rf_tag;
  logic              accept, hit, hit_way, vic_way;
  logic [LINE_W-1:0] rf_entries, sel_line;
  logic              unused_addr_bits;

  assign unused_addr_bits = ^{req_addr[IDX_LO-OFF_W-1:0], refill_addr[IDX_LO-1:0]};
  assign rq_off    = req_addr[BYTE_W +: OFF_W];
  assign rq_idx    = req_addr[IDX_LO +: IDX_W];
  assign rq_tag    = req_addr[TAG_LO +: TAG_W];
  assign rf_idx    = refill_addr[IDX_LO +: IDX_W];
  assign rf_tag    = refill_addr[TAG_LO +: TAG_W];
  assign req_ready = !refill_valid;
  assign accept    = req_valid && req_ready;

  ifc_predecode #(.WORD_W(WORD_W), .NWORDS(LINE_WORDS)) u_pdec (
    .words(refill_line), .flip(refill_flip), .entries(rf_entries)
  );

  ifc_tag_array #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_en(accept), .lk_idx(rq_idx), .lk_tag(rq_tag),
    .lk_hit(hit), .lk_way(hit_way),
    .wr_en(refill_valid), .wr_idx(rf_idx), .wr_tag(rf_tag), .wr_way(vic_way)
  );

  ifc_data_array #(.SETS(SETS), .LINE_W(LINE_W)) u_data (
    .clk(clk), .wr_en(refill_valid), .wr_way(vic_way), .wr_idx(rf_idx),
    .wr_line(rf_entries), .rd_idx(rq_idx), .rd_way(hit_way), .rd_line(sel_line)
  );

  // Lane alignment: lane i takes word off+i unless that runs off the line.
  logic [FETCH_W-1:0]        ln_vld, ln_err;
  logic [FETCH_W*WORD_W-1:0] ln_word;
  logic [FETCH_W*CODE_W-1:0] ln_code;

  always_comb begin
    ln_vld  = '0;
    ln_err  = '0;
    ln_word = '0;
    ln_code = '0;
    for (int i = 0; i < FETCH_W; i++) begin
      logic [OFF_W:0]     pos;
      logic [ENT_W-1:0]   ent;
      pos = {1'b0, rq_off} + (OFF_W+1)'(i);
      ent = sel_line[pos[OFF_W-1:0]*ENT_W +: ENT_W];
      if (hit && !pos[OFF_W]) begin
        ln_vld[i]                   = 1'b1;
        ln_err[i]                   = ^ent;
        ln_word[i*WORD_W +: WORD_W] = ent[WORD_W-1:0];
        ln_code[i*CODE_W +: CODE_W] = ent[WORD_W +: CODE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_lane_valid <= '0;
      rsp_perr       <= '0;
      rsp_words      <= '0;
      rsp_codes      <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_hit        <= hit;
        rsp_lane_valid <= ln_vld;
        rsp_perr       <= ln_err;
        rsp_words      <= ln_word;
        rsp_codes      <= ln_code;
      end
    end
  end
endmodule

// File: rtl/ifc_fetch_cache_chk.sv
module ifc_fetch_cache_chk #(
  parameter int OFF_W   = 4,
  parameter int FETCH_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [OFF_W-1:0]   req_off,
  input logic               refill_valid,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [FETCH_W-1:0] rsp_lane_valid,
  input logic [FETCH_W-1:0] rsp_perr
);
  localparam int LINE_WORDS = 1 << OFF_W;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (req_valid && req_ready) off_q <= req_off;
  end

  function automatic int exp_lanes(input logic [OFF_W-1:0] o);
    int rem;
    rem = LINE_WORDS - int'(o);
    return (rem < FETCH_W) ? rem : FETCH_W;
  endfunction

  // R2: response exactly one cycle after an accepted request
  p_rsp_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);
  // R3: a miss returns no lanes
  p_miss_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_lane_valid == '0));
  // R6: valid lanes start at lane 0, count limited by line end
  p_lane_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_lane_valid & (rsp_lane_valid + 1'b1)) == '0));
  p_lane_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> ($countones(rsp_lane_valid) == exp_lanes(off_q)));
  // R8: parity error only on valid lanes
  p_perr_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_perr & ~rsp_lane_valid) == '0));
  // R10: refill blocks the fetch port
  p_refill_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid |-> !req_ready);
endmodule

bind ifc_fetch_cache ifc_fetch_cache_chk #(.OFF_W(OFF_W), .FETCH_W(FETCH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_off(req_addr[BYTE_W +: OFF_W]), .refill_valid(refill_valid),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_lane_valid(rsp_lane_valid),
  .rsp_perr(rsp_perr)
);

// File: tb/tb_ifc_fetch_cache.sv
module tb_ifc_fetch_cache;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;

  logic         clk = 0, rst_n = 0;
  logic         req_valid = 0, req_ready;
  logic [31:0]  req_addr = '0;
  logic         rsp_valid, rsp_hit;
  logic [3:0]   rsp_lane_valid, rsp_perr;
  logic [127:0] rsp_words;
  logic [15:0]  rsp_codes;
  logic         refill_valid = 0;
  logic [31:0]  refill_addr = '0;
  logic [511:0] refill_line = '0;
  logic [15:0]  refill_flip = '0;

  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifc_fetch_cache dut (.*);

  typedef struct {
    logic         hit;
    logic [3:0]   lv;
    logic [127:0] words;
    logic [15:0]  codes;
    logic [3:0]   perr;
    string        req;
  } exp_t;
  exp_t q[$];

  // Bench reference state
  logic [21:0] mt [NS][2];
  logic        mv [NS][2];
  logic        ml [NS];
  logic [31:0] md [NS][2][16];
  logic        mf [NS][2][16];

  function automatic logic [5:0] pick_op(input int k);
    logic [5:0] ops [16];
    ops = '{6'h00, 6'h02, 6'h04, 6'h07, 6'h08, 6'h0F, 6'h11, 6'h20,
            6'h23, 6'h27, 6'h28, 6'h2B, 6'h2F, 6'h1F, 6'h3A, 6'h30};
    return ops[k % 16];
  endfunction

  function automatic logic [3:0] ref_code(input logic [5:0] op);
    if (op == 6'h00) return 4'b0001;
    if (op >= 6'h08 && op <= 6'h0F) return 4'b0001;
    if (op >= 6'h02 && op <= 6'h07) return 4'b0010;
    if (op >= 6'h20 && op <= 6'h2F) return 4'b0100;
    if (op == 6'h11) return 4'b1000;
    return 4'b0000;
  endfunction

  function automatic logic [31:0] gen_word(input int seed, input int w);
    return {pick_op(seed + w), 26'(seed * 1000 + w * 37 + 5)};
  endfunction

  function automatic logic [31:0] mk_addr(input logic [21:0] tag, input int set, input int off);
    return {tag, 4'(set), 4'(off), 2'b00};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: call at a negedge; holds the request for one cycle.
  task automatic fetch(input logic [31:0] a, input string req);
    exp_t e;
    int s, o, way;
    logic m0, m1;
    s = int'(a[9:6]); o = int'(a[5:2]);
    m0 = mv[s][0] && mt[s][0] == a[31:10];
    m1 = mv[s][1] && mt[s][1] == a[31:10];
    e.hit = m0 ^ m1; e.lv = '0; e.words = '0; e.codes = '0; e.perr = '0; e.req = req;
    way = m1 ? 1 : 0;
    if (e.hit) begin
      ml[s] = (way == 0);
      for (int i = 0; i < 4; i++) if (o + i < 16) begin
        e.lv[i] = 1'b1;
        e.words[i*32 +: 32] = md[s][way][o+i];
        e.codes[i*4 +: 4]   = ref_code(md[s][way][o+i][31:26]);
        e.perr[i]           = mf[s][way][o+i];
      end
    end
    q.push_back(e);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic refill(input logic [21:0] tag, input int set, input int seed,
                        input logic [15:0] flip, input bit with_req);
    int way;
    refill_valid = 1; refill_addr = mk_addr(tag, set, 0); refill_flip = flip;
    for (int w = 0; w < 16; w++) refill_line[w*32 +: 32] = gen_word(seed, w);
    if (with_req) begin req_valid = 1; req_addr = mk_addr(tag, set, 0); end
    #1 check("R10", 128'(req_ready), 128'(0));
    way = ml[set] ? 1 : 0;
    mt[set][way] = tag; mv[set][way] = 1; ml[set] = (way == 0);
    for (int w = 0; w < 16; w++) begin
      md[set][way][w] = gen_word(seed, w) ^ 32'(flip[w]);
      mf[set][way][w] = flip[w];
    end
    @(negedge clk);
    refill_valid = 0; refill_flip = '0; req_valid = 0;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R2 actual=unexpected response expected=none");
      end else begin
        exp_t e;
        e = q.pop_front();
        check({e.req, "/R3 hit"}, 128'(rsp_hit), 128'(e.hit));
        check({e.req, "/R6 lanes"}, 128'(rsp_lane_valid), 128'(e.lv));
        check({e.req, "/R5 words"}, rsp_words & {{32{e.lv[3]}}, {32{e.lv[2]}}, {32{e.lv[1]}}, {32{e.lv[0]}}}, e.words);
        check({e.req, "/R7 codes"}, 128'(rsp_codes & {{4{e.lv[3]}}, {4{e.lv[2]}}, {4{e.lv[1]}}, {4{e.lv[0]}}}), 128'(e.codes));
        check({e.req, "/R8 perr"}, 128'(rsp_perr), 128'(e.perr));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      ml[s] = 0;
      for (int w = 0; w < 2; w++) begin mv[s][w] = 0; mt[s][w] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 ready", 128'(req_ready), 128'(1));
    check("R1 rsp_valid", 128'(rsp_valid), 128'(0));
    // R1/R3: cold misses, back to back
    fetch(mk_addr(22'h1234, 3, 0), "R1");
    fetch(mk_addr(22'h0042, 9, 7), "R3");
    check("R3 ready after miss", 128'(req_ready), 128'(1));
    @(negedge clk);
    check("R2 idle", 128'(rsp_valid), 128'(0));
    // R4/R5/R6/R7: refill then fetch at many offsets
    refill(22'h1234, 3, 1, 16'h0000, 0);
    fetch(mk_addr(22'h1234, 3, 0), "R4");
    fetch(mk_addr(22'h1234, 3, 5), "R5");
    fetch(mk_addr(22'h1234, 3, 12), "R5");
    fetch(mk_addr(22'h1234, 3, 13), "R6");
    fetch(mk_addr(22'h1234, 3, 14), "R6");
    fetch(mk_addr(22'h1234, 3, 15), "R6");
    refill(22'h0777, 10, 2, 16'h0000, 0);
    fetch(mk_addr(22'h0777, 10, 3), "R7");
    fetch(mk_addr(22'h0777, 10, 9), "R7");
    // R8: injected parity faults on words 2 and 15
    refill(22'h0ABC, 5, 3, 16'h8004, 0);
    fetch(mk_addr(22'h0ABC, 5, 0), "R8");
    fetch(mk_addr(22'h0ABC, 5, 14), "R8");
    fetch(mk_addr(22'h0ABC, 5, 4), "R8");
    // R9: replacement order in set 7
    refill(22'h0101, 7, 4, 16'h0000, 0);
    refill(22'h0202, 7, 5, 16'h0000, 0);
    fetch(mk_addr(22'h0101, 7, 1), "R9");
    refill(22'h0303, 7, 6, 16'h0000, 0);
    fetch(mk_addr(22'h0101, 7, 2), "R9");
    fetch(mk_addr(22'h0202, 7, 2), "R9");
    fetch(mk_addr(22'h0303, 7, 2), "R9");
    // R10: request during refill is refused
    refill(22'h0404, 12, 7, 16'h0000, 1);
    @(negedge clk);
    check("R10 no response", 128'(rsp_valid), 128'(0));
    fetch(mk_addr(22'h0404, 12, 0), "R10");
    repeat (3) @(negedge clk);
    check("R2 queue drained", 128'(q.size()), 128'(0));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule